// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block watches a stream of 32-bit configuration words and turns it into decoded events, without altering or holding up the stream. While out of sync it hunts for the bus-width probe pair and the sync word, and every other word has no effect. Once synchronised it parses packet headers. Short write headers name a target register and a word count. A no-operation header carries nothing. A short write with a zero count hands the real length to a long-count header that follows it. Each payload word is then reported with the register it is bound for.

Payload words sent to the command register are also decoded into a command code, with a flag for the four known codes. Words carried by a long-count packet are counted on a bulk-data counter. The desynchronise command ends decoding and sends the block back to hunting. Headers the block cannot accept raise a one-cycle error pulse. All outputs are registered and appear one clock after the word that caused them.

Top module: `cfg_stream_decoder`

## Requirements
- R1: After reset, `sync_active` is 0, every strobe (`bw_detect`, `hdr_strobe`, `pay_strobe`, `cmd_strobe`, `err_hdr`) is 0, and `bulk_count` is 0.
- R2: While not synchronised, words other than the sync word (dummy 0xFFFFFFFF words, headers, payloads) produce no header, payload, command or error strobe.
- R3: While not synchronised, 0x000000BB followed by 0x11220044 as the very next valid word pulses `bw_detect` for one cycle after the second word. 0x11220044 without 0x000000BB directly before it gives no pulse.
- R4: The word 0xAA995566 raises `sync_active` one cycle later. The sync word itself yields no event, and decoding starts with the next valid word.
- R5: While synchronised, a header with bits 31:29 = 001 and bits 28:27 = 00 (e.g. 0x20000000) is a no-operation: no strobe, no error, no payload expected.
- R6: A short write header (bits 31:29 = 001, bits 28:27 = 10) pulses `hdr_strobe` with `hdr_reg` = bits 17:13, `hdr_count` = bits 10:0 and `hdr_long` = 0. The next `count` valid words each pulse `pay_strobe` with `pay_reg` = that register and `pay_data` = the word.
- R7: Each payload word to register 4 also pulses `cmd_strobe` with `cmd_code` = bits 4:0 of the word. `cmd_known` is 1 for codes 0 (null), 1 (write configuration), 7 (reset CRC) and 0x0D (desynchronise), and 0 otherwise.
- R8: A short write with count 0 must be followed by a long header (bits 31:29 = 010, bits 28:27 = 10). That header pulses `hdr_strobe` with `hdr_long` = 1 and `hdr_count` = bits 26:0. The next `count` words are payload for the register named in the short header.
- R9: `bulk_count` clears to 0 when a long header is accepted. It rises by one for each payload word of a long-count packet and holds its value otherwise.
- R10: A desynchronise command word still gives its payload and command strobes, and in that same cycle `sync_active` falls. Later words are not decoded until a new sync word arrives.
- R11: While synchronised, a header of any other type or opcode pulses `err_hdr` and yields no other strobe. A long header not preceded by a zero-count short write, or any non-long word right after a zero-count short write, also pulses `err_hdr`. The block then expects a fresh header and stays synchronised.
- R12: Cycles with `word_valid` low change no state and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Qualifies `word_data` this cycle |
| word_data | input | 32 | Configuration stream word |
| sync_active | output | 1 | Decoder is synchronised and parsing packets |
| bw_detect | output | 1 | Bus-width probe pair seen (one-cycle pulse) |
| hdr_strobe | output | 1 | A write header was accepted |
| hdr_long | output | 1 | The accepted header was the long-count form |
| hdr_reg | output | 5 | Register index of a short header |
| hdr_count | output | 27 | Word count of the accepted header |
| pay_strobe | output | 1 | A payload word is being reported |
| pay_reg | output | 5 | Target register of the payload word |
| pay_data | output | 32 | The payload word |
| cmd_strobe | output | 1 | Payload word to the command register |
| cmd_code | output | 5 | Command code from the payload |
| cmd_known | output | 1 | Command code is one of the four recognised |
| bulk_count | output | 27 | Payload words received under the current long count |
| err_hdr | output | 1 | Unacceptable header (one-cycle pulse) |

## Verification
The desynchronise word is where three functions meet in one cycle: it is reported as a payload word, decoded as a command, and it drops synchronisation. The bench sends a one-word write to the command register carrying 0x0D. It then checks, in the single cycle after that word, that the payload strobe, the command strobe with code 0x0D and a low `sync_active` all appear together. It then confirms that a following header yields nothing until the sync word is sent again. A second overlap, the bulk counter stepping in the same cycle as a payload strobe, is judged on every word of a three-word long packet.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 5;
    localparam int SCNT_W = 11;
    localparam int LCNT_W = 27;
    localparam int CMD_W  = 5;

    localparam logic [WORD_W-1:0] W_BW_FIRST  = 32'h0000_00BB;
    localparam logic [WORD_W-1:0] W_BW_SECOND = 32'h1122_0044;
    localparam logic [WORD_W-1:0] W_SYNC      = 32'hAA99_5566;

    localparam logic [2:0] HT_SHORT = 3'b001;
    localparam logic [2:0] HT_LONG  = 3'b010;
    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b10;

    localparam logic [REG_W-1:0] REG_COMMAND = 5'd4;

    localparam logic [CMD_W-1:0] CMD_NULL   = 5'h00;
    localparam logic [CMD_W-1:0] CMD_WCFG   = 5'h01;
    localparam logic [CMD_W-1:0] CMD_RCRC   = 5'h07;
    localparam logic [CMD_W-1:0] CMD_DESYNC = 5'h0D;

    typedef enum logic [1:0] {HK_NOOP, HK_SHORT_WR, HK_LONG_WR, HK_BAD} hdr_kind_e;
    typedef enum logic [1:0] {SY_HUNT, SY_BW, SY_LOCK} sync_state_e;
    typedef enum logic [1:0] {PK_HDR, PK_LONG, PK_PAY} pk_state_e;

    typedef struct packed {
        hdr_kind_e           kind;
        logic [REG_W-1:0]    regsel;
        logic [LCNT_W-1:0]   count;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.kind   = HK_BAD;
        h.regsel = w[17:13];
        h.count  = '0;
        if (w[31:29] == HT_SHORT) begin
            if (w[28:27] == OP_NONE) begin
                h.kind = HK_NOOP;
            end else if (w[28:27] == OP_WRITE) begin
                h.kind  = HK_SHORT_WR;
                h.count = LCNT_W'(w[SCNT_W-1:0]);
            end
        end else if (w[31:29] == HT_LONG && w[28:27] == OP_WRITE) begin
            h.kind   = HK_LONG_WR;
            h.regsel = '0;
            h.count  = w[LCNT_W-1:0];
        end
        return h;
    endfunction

    function automatic logic cmd_recognised(input logic [CMD_W-1:0] c);
        return (c == CMD_NULL) || (c == CMD_WCFG) || (c == CMD_RCRC) || (c == CMD_DESYNC);
    endfunction

endpackage

// File: rtl/cfgdec_sync.sv
module cfgdec_sync
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              desync_req_i,
    output logic              locked_o,
    output logic              bw_pulse_o
);

    sync_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SY_HUNT;
            bw_pulse_o <= 1'b0;
        end else begin
            bw_pulse_o <= 1'b0;
            if (valid_i) begin
                if (state_q == SY_LOCK) begin
                    if (desync_req_i) state_q <= SY_HUNT;
                end else if (word_i == W_SYNC) begin
                    state_q <= SY_LOCK;
                end else if (word_i == W_BW_FIRST) begin
                    state_q <= SY_BW;
                end else begin
                    if (state_q == SY_BW && word_i == W_BW_SECOND) bw_pulse_o <= 1'b1;
                    state_q <= SY_HUNT;
                end
            end
        end
    end

    assign locked_o = (state_q == SY_LOCK);

    // R4: lock is entered only from a valid sync word
    p_lock_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> ($past(valid_i) && $past(word_i) == W_SYNC));

    // R3: the probe pulse is only produced while hunting
    p_bw_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
        bw_pulse_o |-> !locked_o);

endmodule

// File: rtl/cfgdec_cmd.sv
module cfgdec_cmd
    import cfgdec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [CMD_W-1:0]  code_o,
    output logic              known_o,
    output logic              desync_o
);

    always_comb begin
        code_o   = word_i[CMD_W-1:0];
        known_o  = cmd_recognised(code_o);
        desync_o = (code_o == CMD_DESYNC);
    end

endmodule

// File: rtl/cfgdec_packet.sv
module cfgdec_packet
    import cfgdec_pkg::*;
#(
    parameter int BULK_W = LCNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              synced_i,
    output logic              hdr_strobe_o,
    output logic              hdr_long_o,
    output logic [REG_W-1:0]  hdr_reg_o,
    output logic [LCNT_W-1:0] hdr_count_o,
    output logic              pay_strobe_o,
    output logic [REG_W-1:0]  pay_reg_o,
    output logic [WORD_W-1:0] pay_data_o,
    output logic              cmd_strobe_o,
    output logic [CMD_W-1:0]  cmd_code_o,
    output logic              cmd_known_o,
    output logic [BULK_W-1:0] bulk_count_o,
    output logic              err_o,
    output logic              desync_req_o
);

    pk_state_e          state_q;
    logic [LCNT_W-1:0]  remain_q;
    logic [REG_W-1:0]   reg_q;
    logic               in_long_q;
    hdr_t               hdr;
    logic [CMD_W-1:0]   c_code;
    logic               c_known;
    logic               c_desync;
    logic               take;

    cfgdec_cmd u_cmd (
        .word_i   (word_i),
        .code_o   (c_code),
        .known_o  (c_known),
        .desync_o (c_desync)
    );

    always_comb begin
        hdr          = decode_hdr(word_i);
        take         = valid_i && synced_i;
        desync_req_o = take && (state_q == PK_PAY) && (reg_q == REG_COMMAND) && c_desync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= PK_HDR;
            remain_q     <= '0;
            reg_q        <= '0;
            in_long_q    <= 1'b0;
            hdr_strobe_o <= 1'b0;
            hdr_long_o   <= 1'b0;
            hdr_reg_o    <= '0;
            hdr_count_o  <= '0;
            pay_strobe_o <= 1'b0;
            pay_reg_o    <= '0;
            pay_data_o   <= '0;
            cmd_strobe_o <= 1'b0;
            cmd_code_o   <= '0;
            cmd_known_o  <= 1'b0;
            bulk_count_o <= '0;
            err_o        <= 1'b0;
        end else begin
            hdr_strobe_o <= 1'b0;
            pay_strobe_o <= 1'b0;
            cmd_strobe_o <= 1'b0;
            err_o        <= 1'b0;
            if (!synced_i) begin
                state_q <= PK_HDR;
            end else if (take) begin
                unique case (state_q)
                    PK_HDR: begin
                        if (hdr.kind == HK_SHORT_WR) begin
                            hdr_strobe_o <= 1'b1;
                            hdr_long_o   <= 1'b0;
                            hdr_reg_o    <= hdr.regsel;
                            hdr_count_o  <= hdr.count;
                            reg_q        <= hdr.regsel;
                            remain_q     <= hdr.count;
                            in_long_q    <= 1'b0;
                            state_q      <= (hdr.count == '0) ? PK_LONG : PK_PAY;
                        end else if (hdr.kind != HK_NOOP) begin
                            err_o <= 1'b1;
                        end
                    end
                    PK_LONG: begin
                        if (hdr.kind == HK_LONG_WR) begin
                            hdr_strobe_o <= 1'b1;
                            hdr_long_o   <= 1'b1;
                            hdr_reg_o    <= reg_q;
                            hdr_count_o  <= hdr.count;
                            remain_q     <= hdr.count;
                            in_long_q    <= 1'b1;
                            bulk_count_o <= '0;
                            state_q      <= (hdr.count == '0) ? PK_HDR : PK_PAY;
                        end else begin
                            err_o   <= 1'b1;
                            state_q <= PK_HDR;
                        end
                    end
                    PK_PAY: begin
                        pay_strobe_o <= 1'b1;
                        pay_reg_o    <= reg_q;
                        pay_data_o   <= word_i;
                        if (in_long_q) bulk_count_o <= bulk_count_o + 1'b1;
                        if (reg_q == REG_COMMAND) begin
                            cmd_strobe_o <= 1'b1;
                            cmd_code_o   <= c_code;
                            cmd_known_o  <= c_known;
                        end
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == LCNT_W'(1) || desync_req_o) state_q <= PK_HDR;
                    end
                    default: state_q <= PK_HDR;
                endcase
            end
        end
    end

    // R4: payload is reported only for words taken while synchronised
    p_pay_synced_r4: assert property (@(posedge clk) disable iff (rst)
        pay_strobe_o |-> $past(synced_i));

    // R12: an idle cycle leaves the bulk counter and the strobes alone
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(bulk_count_o) && !pay_strobe_o && !hdr_strobe_o));

    // R7: a command event is always a payload event to the command register
    p_cmd_payload_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe_o |-> (pay_strobe_o && pay_reg_o == REG_COMMAND));

endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
    import cfgdec_pkg::*;
#(
    parameter int BULK_W = LCNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [31:0]       word_data,
    output logic              sync_active,
    output logic              bw_detect,
    output logic              hdr_strobe,
    output logic              hdr_long,
    output logic [4:0]        hdr_reg,
    output logic [26:0]       hdr_count,
    output logic              pay_strobe,
    output logic [4:0]        pay_reg,
    output logic [31:0]       pay_data,
    output logic              cmd_strobe,
    output logic [4:0]        cmd_code,
    output logic              cmd_known,
    output logic [BULK_W-1:0] bulk_count,
    output logic              err_hdr
);

    logic desync_req;

    cfgdec_sync u_sync (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (word_valid),
        .word_i       (word_data),
        .desync_req_i (desync_req),
        .locked_o     (sync_active),
        .bw_pulse_o   (bw_detect)
    );

    cfgdec_packet #(.BULK_W(BULK_W)) u_packet (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (word_valid),
        .word_i       (word_data),
        .synced_i     (sync_active),
        .hdr_strobe_o (hdr_strobe),
        .hdr_long_o   (hdr_long),
        .hdr_reg_o    (hdr_reg),
        .hdr_count_o  (hdr_count),
        .pay_strobe_o (pay_strobe),
        .pay_reg_o    (pay_reg),
        .pay_data_o   (pay_data),
        .cmd_strobe_o (cmd_strobe),
        .cmd_code_o   (cmd_code),
        .cmd_known_o  (cmd_known),
        .bulk_count_o (bulk_count),
        .err_o        (err_hdr),
        .desync_req_o (desync_req)
    );

    // R10: a desynchronise command is reported in the cycle the lock drops
    p_desync_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && cmd_code == CMD_DESYNC) |-> !sync_active);

    // R11: header, payload and error events never coincide
    p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_strobe, pay_strobe, err_hdr}));

endmodule

// File: tb/cfg_stream_decoder_bench.sv
module cfg_stream_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        sync_active, bw_detect, hdr_strobe, hdr_long;
    logic [4:0]  hdr_reg, pay_reg, cmd_code;
    logic [26:0] hdr_count, bulk_count;
    logic        pay_strobe, cmd_strobe, cmd_known, err_hdr;
    logic [31:0] pay_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_stream_decoder u_cfg_stream_decoder (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
        .sync_active(sync_active), .bw_detect(bw_detect), .hdr_strobe(hdr_strobe),
        .hdr_long(hdr_long), .hdr_reg(hdr_reg), .hdr_count(hdr_count),
        .pay_strobe(pay_strobe), .pay_reg(pay_reg), .pay_data(pay_data),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_known(cmd_known),
        .bulk_count(bulk_count), .err_hdr(err_hdr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one word, let one edge take it, sample at the following falling edge
    task automatic send(input logic [31:0] w);
        word_valid = 1'b1;
        word_data  = w;
        @(posedge clk);
        #1 word_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet(input string req);
        chk(req, "hdr_strobe", 32'(hdr_strobe), 0);
        chk(req, "pay_strobe", 32'(pay_strobe), 0);
        chk(req, "cmd_strobe", 32'(cmd_strobe), 0);
        chk(req, "err_hdr",    32'(err_hdr),    0);
    endtask

    task automatic t_reset();
        chk("R1", "sync_active", 32'(sync_active), 0);
        chk("R1", "bw_detect",   32'(bw_detect),   0);
        chk("R1", "bulk_count",  32'(bulk_count),  0);
        quiet("R1");
    endtask

    task automatic t_hunt();
        send(32'hFFFF_FFFF); quiet("R2");
        send(32'h3000_8001); quiet("R2");
        send(32'h0000_0007); quiet("R2");
        chk("R2", "sync_active", 32'(sync_active), 0);
        send(32'h1122_0044);
        chk("R3", "bw lone second word", 32'(bw_detect), 0);
        send(32'h0000_00BB);
        send(32'hFFFF_FFFF);
        send(32'h1122_0044);
        chk("R3", "bw interrupted pair", 32'(bw_detect), 0);
        send(32'h0000_00BB);
        chk("R3", "bw after first word", 32'(bw_detect), 0);
        send(32'h1122_0044);
        chk("R3", "bw pair", 32'(bw_detect), 1);
        send(32'hFFFF_FFFF);
        chk("R3", "bw one cycle", 32'(bw_detect), 0);
    endtask

    task automatic t_sync();
        send(32'hAA99_5566);
        chk("R4", "sync_active", 32'(sync_active), 1);
        quiet("R4");
        send(32'h2000_0000);
        quiet("R5");
        chk("R5", "still synced", 32'(sync_active), 1);
    endtask

    task automatic t_write();
        send(32'h3001_8001);
        chk("R6", "hdr_strobe", 32'(hdr_strobe), 1);
        chk("R6", "hdr_reg",    32'(hdr_reg),    32'h0C);
        chk("R6", "hdr_count",  32'(hdr_count),  1);
        chk("R6", "hdr_long",   32'(hdr_long),   0);
        idle_cycle();
        chk("R12", "no pay on gap", 32'(pay_strobe), 0);
        send(32'h0372_2093);
        chk("R6", "pay_strobe", 32'(pay_strobe), 1);
        chk("R6", "pay_reg",    32'(pay_reg),    32'h0C);
        chk("R6", "pay_data",   pay_data,        32'h0372_2093);
        chk("R7", "no cmd on id write", 32'(cmd_strobe), 0);
        send(32'h3000_A002);
        chk("R6", "hdr_reg ctl", 32'(hdr_reg),   5);
        chk("R6", "hdr_count 2", 32'(hdr_count), 2);
        send(32'h0000_0100);
        chk("R6", "pay 1 of 2", 32'(pay_strobe), 1);
        chk("R6", "pay_reg ctl", 32'(pay_reg), 5);
        send(32'h2000_0000);
        chk("R6", "pay 2 of 2 (noop-like word)", 32'(pay_strobe), 1);
        chk("R6", "pay_data 2", pay_data, 32'h2000_0000);
        send(32'h2000_0000);
        chk("R6", "packet closed", 32'(pay_strobe), 0);
    endtask

    task automatic t_cmd();
        send(32'h3000_8001);
        send(32'h0000_0007);
        chk("R7", "cmd_strobe", 32'(cmd_strobe), 1);
        chk("R7", "cmd_code",   32'(cmd_code),   7);
        chk("R7", "cmd_known",  32'(cmd_known),  1);
        send(32'h3000_8001);
        send(32'h0000_0003);
        chk("R7", "cmd_code 3",  32'(cmd_code),  3);
        chk("R7", "cmd unknown", 32'(cmd_known), 0);
        send(32'h3000_8001);
        send(32'h0000_0001);
        chk("R7", "wcfg known", 32'(cmd_known), 1);
    endtask

    task automatic t_long();
        send(32'h3000_4000);
        chk("R8", "zero hdr strobe", 32'(hdr_strobe), 1);
        chk("R8", "zero hdr reg",    32'(hdr_reg),    2);
        chk("R8", "zero hdr count",  32'(hdr_count),  0);
        send(32'h5000_0003);
        chk("R8", "long hdr strobe", 32'(hdr_strobe), 1);
        chk("R8", "hdr_long",        32'(hdr_long),   1);
        chk("R8", "long count",      32'(hdr_count),  3);
        chk("R9", "bulk cleared",    32'(bulk_count), 0);
        for (int i = 1; i <= 3; i++) begin
            send(32'hC0DE_0000 + 32'(i));
            chk("R8", "long pay strobe", 32'(pay_strobe), 1);
            chk("R8", "long pay reg",    32'(pay_reg),    2);
            chk("R9", "bulk step",       32'(bulk_count), 32'(i));
        end
        idle_cycle();
        chk("R12", "bulk on gap", 32'(bulk_count), 3);
        send(32'h3000_2001);
        chk("R8", "next hdr after long", 32'(hdr_strobe), 1);
        chk("R9", "bulk holds", 32'(bulk_count), 3);
        send(32'h0000_1900);
        chk("R9", "bulk not counting short", 32'(bulk_count), 3);
        send(32'h3000_4000);
        send(32'h5000_0001);
        chk("R9", "bulk cleared again", 32'(bulk_count), 0);
        send(32'h1234_5678);
        chk("R9", "bulk one", 32'(bulk_count), 1);
    endtask

    task automatic t_err();
        send(32'hFFFF_FFFF);
        chk("R11", "bad type err", 32'(err_hdr), 1);
        chk("R11", "no hdr",       32'(hdr_strobe), 0);
        send(32'h5000_0002);
        chk("R11", "stray long err", 32'(err_hdr), 1);
        send(32'h2800_0000);
        chk("R11", "read opcode err", 32'(err_hdr), 1);
        send(32'h3000_4000);
        send(32'h3000_8001);
        chk("R11", "missing long err", 32'(err_hdr), 1);
        chk("R11", "still synced", 32'(sync_active), 1);
        send(32'h3000_2001);
        chk("R11", "recovers", 32'(hdr_strobe), 1);
        send(32'h0000_0000);
    endtask

    task automatic t_desync();
        send(32'h3000_8001);
        send(32'h0000_000D);
        chk("R10", "pay strobe", 32'(pay_strobe), 1);
        chk("R10", "cmd strobe", 32'(cmd_strobe), 1);
        chk("R10", "cmd code",   32'(cmd_code),   32'h0D);
        chk("R10", "cmd known",  32'(cmd_known),  1);
        chk("R10", "sync dropped", 32'(sync_active), 0);
        send(32'h3000_8001); quiet("R10");
        send(32'h0000_0007); quiet("R10");
        send(32'hAA99_5566);
        chk("R10", "resync", 32'(sync_active), 1);
        send(32'h3000_2001);
        chk("R10", "decoding again", 32'(hdr_strobe), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hunt();
        t_sync();
        t_write();
        t_cmd();
        t_long();
        t_err();
        t_desync();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule